// File: doc/BRIEF.md
# Jacobian Point Doubling Sequencer

This block steps through a fixed microprogram that doubles an elliptic-curve point held in Jacobian coordinates. It performs no arithmetic itself. A separate modular arithmetic unit owns a small register bank and does the work. For each step, the sequencer presents one micro-operation to that unit: copy, modular add, modular subtract or modular multiply. Each micro-operation names two source registers and one destination register. The sequencer holds the operation until the unit acknowledges it, then moves to the next step.

The program computes the usual doubling for curves with a = -3. Tripling is done with two additions, and halving is done by multiplying with a stored constant equal to 2^-1 mod q. The multiplier must never receive the same register on both operand ports, so every squaring is first copied into a scratch register.

When the run starts, the caller supplies a flag that tells whether the input z coordinate is zero. The sequencer captures this flag on the start cycle. If it was set, three extra copy steps follow the main program and overwrite the result with the point at infinity, (1, 1, 0). When all steps have finished, a one-cycle completion pulse is given.

The controller is a four-state machine:
- IDLE waits for start.
- ISSUE drives a micro-operation and waits for the acknowledge.
- ADVANCE decides whether another step follows.
- DONE gives the completion pulse.

Transitions:
- IDLE to ISSUE on start.
- ISSUE to ADVANCE on acknowledge.
- ADVANCE back to ISSUE when further steps remain.
- ADVANCE to DONE after the last step.
- DONE to IDLE unconditionally.

Top module: `dbl_seq`

## Requirements
- R1: After reset, and whenever the block is idle, op_valid, busy and done are all low.
- R2: A start pulse while idle captures z_zero and raises busy and op_valid on the next cycle.
- R3: While op_valid is high and op_ack is low, op_valid and all operation fields hold their values.
- R4: A multiply step never carries the same index on both source fields.
- R5: The opcode encoding is COPY=0, ADD=1, SUB=2, MUL=3.
- R6: The register bank indices are:
  - 0 px, 1 py, 2 pz
  - 3 rx, 4 ry, 5 rz
  - 6 t1, 7 t2, 8 t3
  - 9 the constant one, 10 the constant zero
  - 11 the constant 2^-1 mod q
- R7: For an input with nonzero z, the bank ends holding rx = M^2 - 2S, ry = M(S - rx) - 8y^4 and rz = 2yz (mod q), where M = 3(x - z^2)(x + z^2) and S = 4xy^2.
- R8: With z_zero captured low, exactly 23 micro-operations are issued.
- R9: With z_zero captured high, 26 micro-operations are issued and the bank ends holding (rx, ry, rz) = (1, 1, 0).
- R10: After the acknowledge of the final step, done is high for exactly one cycle, with op_valid low, and busy falls after it.
- R11: A start pulse while busy is ignored. So is any change of z_zero after the start cycle. Neither alters the step count or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a doubling run (honoured only when idle) |
| z_zero_i | input | 1 | Input z coordinate is zero; captured with start |
| op_ack_i | input | 1 | Arithmetic unit has completed the presented operation |
| op_valid_o | output | 1 | A micro-operation is being presented |
| op_kind_o | output | 2 | Opcode of the presented operation |
| op_src_a_o | output | 4 | First source register index |
| op_src_b_o | output | 4 | Second source register index |
| op_dst_o | output | 4 | Destination register index |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the arithmetic unit raises op_ack only while op_valid is high, and only as a single-cycle pulse for each operation. The bench's responder model therefore acknowledges only a presented operation, after a wait of zero to two cycles, and always drops the acknowledge on the following cycle. The assertions also assume that z_zero truly reflects the z register at the start cycle. The bench drives z_zero from the same z value it loads into its model bank, except in runs that deliberately toggle the flag after start to show that it is ignored.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

    // Register bank addressing of the external arithmetic unit
    localparam int REG_IDX_W = 4;
    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    localparam reg_idx_t RG_PX   = reg_idx_t'(0);
    localparam reg_idx_t RG_PY   = reg_idx_t'(1);
    localparam reg_idx_t RG_PZ   = reg_idx_t'(2);
    localparam reg_idx_t RG_RX   = reg_idx_t'(3);
    localparam reg_idx_t RG_RY   = reg_idx_t'(4);
    localparam reg_idx_t RG_RZ   = reg_idx_t'(5);
    localparam reg_idx_t RG_T1   = reg_idx_t'(6);
    localparam reg_idx_t RG_T2   = reg_idx_t'(7);
    localparam reg_idx_t RG_T3   = reg_idx_t'(8);
    localparam reg_idx_t RG_ONE  = reg_idx_t'(9);
    localparam reg_idx_t RG_ZERO = reg_idx_t'(10);
    localparam reg_idx_t RG_HALF = reg_idx_t'(11);

    // Micro-operation encoding
    localparam int OP_KIND_W = 2;
    typedef enum logic [OP_KIND_W-1:0] {
        OP_COPY = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_MUL  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
    } micro_op_t;

    // Program length
    localparam int MAIN_STEPS = 23;
    localparam int FIX_STEPS  = 3;
    localparam int ALL_STEPS  = MAIN_STEPS + FIX_STEPS;
    localparam int STEP_W     = $clog2(ALL_STEPS);
    typedef logic [STEP_W-1:0] step_t;

    localparam step_t MAIN_LAST = step_t'(MAIN_STEPS - 1);
    localparam step_t ALL_LAST  = step_t'(ALL_STEPS - 1);

    // Controller states
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ISSUE   = 2'd1,
        S_ADVANCE = 2'd2,
        S_DONE    = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dbl_rom.sv
module dbl_rom
    import dbl_pkg::*;
(
    input  step_t     step_i,
    output micro_op_t uop_o
);

    function automatic micro_op_t mk(op_kind_e k, reg_idx_t a, reg_idx_t b, reg_idx_t d);
        micro_op_t u;
        u.kind  = k;
        u.src_a = a;
        u.src_b = b;
        u.dst   = d;
        return u;
    endfunction

    always_comb begin
        case (step_i)
            // square of z into t1 (copy first: multiplier needs distinct operands)
            step_t'(0):  uop_o = mk(OP_COPY, RG_PZ, RG_PZ, RG_T1);
            step_t'(1):  uop_o = mk(OP_MUL,  RG_PZ, RG_T1, RG_T1);
            // (x - z^2) and (x + z^2)
            step_t'(2):  uop_o = mk(OP_SUB,  RG_PX, RG_T1, RG_T2);
            step_t'(3):  uop_o = mk(OP_ADD,  RG_PX, RG_T1, RG_T1);
            step_t'(4):  uop_o = mk(OP_MUL,  RG_T1, RG_T2, RG_T2);
            // tripling via two additions
            step_t'(5):  uop_o = mk(OP_ADD,  RG_T2, RG_T2, RG_T1);
            step_t'(6):  uop_o = mk(OP_ADD,  RG_T1, RG_T2, RG_T2);
            // 2y and new z
            step_t'(7):  uop_o = mk(OP_ADD,  RG_PY, RG_PY, RG_RY);
            step_t'(8):  uop_o = mk(OP_MUL,  RG_PZ, RG_RY, RG_RZ);
            // (2y)^2 through two scratch copies
            step_t'(9):  uop_o = mk(OP_COPY, RG_RY, RG_RY, RG_T1);
            step_t'(10): uop_o = mk(OP_COPY, RG_RY, RG_RY, RG_T3);
            step_t'(11): uop_o = mk(OP_MUL,  RG_T1, RG_T3, RG_RY);
            step_t'(12): uop_o = mk(OP_MUL,  RG_PX, RG_RY, RG_T3);
            // (4y^2)^2 then halved by the stored inverse of two
            step_t'(13): uop_o = mk(OP_COPY, RG_RY, RG_RY, RG_T1);
            step_t'(14): uop_o = mk(OP_MUL,  RG_RY, RG_T1, RG_T1);
            step_t'(15): uop_o = mk(OP_MUL,  RG_T1, RG_HALF, RG_RY);
            // new x
            step_t'(16): uop_o = mk(OP_COPY, RG_T2, RG_T2, RG_T1);
            step_t'(17): uop_o = mk(OP_MUL,  RG_T1, RG_T2, RG_RX);
            step_t'(18): uop_o = mk(OP_ADD,  RG_T3, RG_T3, RG_T1);
            step_t'(19): uop_o = mk(OP_SUB,  RG_RX, RG_T1, RG_RX);
            // new y
            step_t'(20): uop_o = mk(OP_SUB,  RG_T3, RG_RX, RG_T1);
            step_t'(21): uop_o = mk(OP_MUL,  RG_T1, RG_T2, RG_T1);
            step_t'(22): uop_o = mk(OP_SUB,  RG_T1, RG_RY, RG_RY);
            // point-at-infinity override tail
            step_t'(23): uop_o = mk(OP_COPY, RG_ONE,  RG_ONE,  RG_RX);
            step_t'(24): uop_o = mk(OP_COPY, RG_ONE,  RG_ONE,  RG_RY);
            step_t'(25): uop_o = mk(OP_COPY, RG_ZERO, RG_ZERO, RG_RZ);
            default:     uop_o = mk(OP_COPY, RG_ZERO, RG_ZERO, RG_ZERO);
        endcase
    end

endmodule

// File: rtl/dbl_step_ctr.sv
module dbl_step_ctr
    import dbl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_i,
    input  logic  advance_i,
    input  logic  inf_i,
    output step_t step_o,
    output logic  last_o
);

    step_t step_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (clear_i) begin
            step_q <= '0;
        end else if (advance_i) begin
            step_q <= step_q + step_t'(1);
        end
    end

    always_comb begin
        if (inf_i) begin
            last_o = (step_q == ALL_LAST);
        end else begin
            last_o = (step_q == MAIN_LAST);
        end
    end

    assign step_o = step_q;

endmodule

// File: rtl/dbl_fsm.sv
module dbl_fsm
    import dbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic z_zero_i,
    input  logic ack_i,
    input  logic last_i,
    output logic clear_o,
    output logic advance_o,
    output logic inf_o,
    output logic op_valid_o,
    output logic busy_o,
    output logic done_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       inf_q;

    // state register and captured infinity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            inf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                inf_q <= z_zero_i;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (ack_i) begin
                    state_d = S_ADVANCE;
                end
            end
            S_ADVANCE: begin
                if (last_i) begin
                    state_d = S_DONE;
                end else begin
                    state_d = S_ISSUE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        clear_o    = 1'b0;
        advance_o  = 1'b0;
        op_valid_o = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o  = 1'b0;
                clear_o = start_i;
            end
            S_ISSUE: begin
                op_valid_o = 1'b1;
            end
            S_ADVANCE: begin
                advance_o = !last_i;
            end
            S_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign inf_o = inf_q;

endmodule

// File: rtl/dbl_seq.sv
module dbl_seq
    import dbl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 z_zero_i,
    input  logic                 op_ack_i,
    output logic                 op_valid_o,
    output logic [OP_KIND_W-1:0] op_kind_o,
    output logic [REG_IDX_W-1:0] op_src_a_o,
    output logic [REG_IDX_W-1:0] op_src_b_o,
    output logic [REG_IDX_W-1:0] op_dst_o,
    output logic                 busy_o,
    output logic                 done_o
);

    logic      clear;
    logic      advance;
    logic      inf_flag;
    logic      last_step;
    step_t     step;
    micro_op_t uop;

    dbl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .z_zero_i   (z_zero_i),
        .ack_i      (op_ack_i),
        .last_i     (last_step),
        .clear_o    (clear),
        .advance_o  (advance),
        .inf_o      (inf_flag),
        .op_valid_o (op_valid_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    dbl_step_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .advance_i (advance),
        .inf_i     (inf_flag),
        .step_o    (step),
        .last_o    (last_step)
    );

    dbl_rom u_rom (
        .step_i (step),
        .uop_o  (uop)
    );

    assign op_kind_o  = uop.kind;
    assign op_src_a_o = uop.src_a;
    assign op_src_b_o = uop.src_b;
    assign op_dst_o   = uop.dst;

endmodule

// File: rtl/dbl_seq_chk.sv
module dbl_seq_chk
    import dbl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 op_ack_i,
    input logic                 op_valid_o,
    input logic [OP_KIND_W-1:0] op_kind_o,
    input logic [REG_IDX_W-1:0] op_src_a_o,
    input logic [REG_IDX_W-1:0] op_src_b_o,
    input logic [REG_IDX_W-1:0] op_dst_o,
    input logic                 busy_o,
    input logic                 done_o
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!op_valid_o && !done_o));

    a_r2_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && op_valid_o));

    a_r3_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && !op_ack_i) |=> (op_valid_o && $stable(op_kind_o)
            && $stable(op_src_a_o) && $stable(op_src_b_o) && $stable(op_dst_o)));

    a_r4_mul_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && op_kind_o == OP_MUL) |-> (op_src_a_o != op_src_b_o));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_no_op: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !op_valid_o));

    a_r10_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    a_r3_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && op_ack_i) |=> !op_valid_o);

endmodule

bind dbl_seq dbl_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_ack_i   (op_ack_i),
    .op_valid_o (op_valid_o),
    .op_kind_o  (op_kind_o),
    .op_src_a_o (op_src_a_o),
    .op_src_b_o (op_src_b_o),
    .op_dst_o   (op_dst_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/dbl_seq_bench.sv
`timescale 1ns/1ps
module dbl_seq_bench;

    localparam int Q        = 11;
    localparam int HALF     = (Q + 1) / 2;
    localparam int WDOG_MAX = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       z_zero_i = 1'b0;
    logic       op_ack_i = 1'b0;
    logic       op_valid_o;
    logic [1:0] op_kind_o;
    logic [3:0] op_src_a_o;
    logic [3:0] op_src_b_o;
    logic [3:0] op_dst_o;
    logic       busy_o;
    logic       done_o;

    int bank [16];
    int lat;
    int wcnt;
    int ops_seen;
    int mul_clash;
    int hold_err;
    int kind_err;
    logic [13:0] held;
    logic        have_held;
    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dbl_seq u_dbl_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .z_zero_i   (z_zero_i),
        .op_ack_i   (op_ack_i),
        .op_valid_o (op_valid_o),
        .op_kind_o  (op_kind_o),
        .op_src_a_o (op_src_a_o),
        .op_src_b_o (op_src_b_o),
        .op_dst_o   (op_dst_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    function automatic int md(int v);
        return ((v % Q) + Q) % Q;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_MAX) begin
                chk(1'b0, "watchdog", cycles, WDOG_MAX);
                finish_run();
            end
        end
    end

    // arithmetic unit model (opcodes per R5, bank indices per R6)
    initial begin
        wcnt = 0;
        have_held = 1'b0;
        forever begin
            @(negedge clk);
            if (op_ack_i) begin
                op_ack_i = 1'b0;
                have_held = 1'b0;
            end else if (rst_n && op_valid_o) begin
                if (!have_held) begin
                    held = {op_kind_o, op_src_a_o, op_src_b_o, op_dst_o};
                    have_held = 1'b1;
                end else if (held != {op_kind_o, op_src_a_o, op_src_b_o, op_dst_o}) begin
                    hold_err++;
                end
                if (wcnt >= lat) begin
                    ops_seen++;
                    if (op_kind_o == 2'd3 && op_src_a_o == op_src_b_o) mul_clash++;
                    case (op_kind_o)
                        2'd0: bank[op_dst_o] = bank[op_src_a_o];
                        2'd1: bank[op_dst_o] = md(bank[op_src_a_o] + bank[op_src_b_o]);
                        2'd2: bank[op_dst_o] = md(bank[op_src_a_o] - bank[op_src_b_o]);
                        default: bank[op_dst_o] = md(bank[op_src_a_o] * bank[op_src_b_o]);
                    endcase
                    if (op_dst_o > 4'd8) kind_err++;
                    op_ack_i = 1'b1;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic run_point(int x, int y, int z, int lat_i, bit disturb, bit full);
        int guard;
        int ex, ey, ez, m, s, y2;
        int exp_ops;
        for (int i = 0; i < 16; i++) bank[i] = 5;
        bank[0] = x; bank[1] = y; bank[2] = z;
        bank[9] = 1; bank[10] = 0; bank[11] = HALF;
        lat = lat_i; ops_seen = 0; mul_clash = 0; hold_err = 0; kind_err = 0;
        @(negedge clk);
        start_i = 1'b1;
        z_zero_i = (z == 0);
        @(negedge clk);
        start_i = 1'b0;
        if (full) chk(busy_o && op_valid_o, "R2 busy/valid after start", int'(busy_o), 1);
        guard = 0;
        while (!done_o && guard < 3000) begin
            if (disturb && guard == 8) begin
                start_i = 1'b1;
                z_zero_i = !z_zero_i;
            end else if (disturb && guard == 9) begin
                start_i = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        chk(done_o == 1'b1, "R10 done seen", int'(done_o), 1);
        if (full) chk(!op_valid_o, "R10 no op with done", int'(op_valid_o), 0);
        @(negedge clk);
        if (full) chk(!done_o && !busy_o, "R10 done single cycle and busy low",
                      int'(done_o) + 2 * int'(busy_o), 0);
        if (z == 0) begin
            ex = 1; ey = 1; ez = 0; exp_ops = 26;
        end else begin
            m  = md(3 * md(x - z * z) * md(x + z * z));
            y2 = md(y * y);
            s  = md(4 * x * y2);
            ex = md(m * m - 2 * s);
            ey = md(m * md(s - ex) - 8 * md(y2 * y2));
            ez = md(2 * y * z);
            exp_ops = 23;
        end
        if (z == 0) begin
            chk(bank[3] == ex && bank[4] == ey && bank[5] == ez, disturb ? "R11 R9 infinity result" : "R9 infinity result",
                bank[3] * 100 + bank[4] * 10 + bank[5], ex * 100 + ey * 10 + ez);
            chk(ops_seen == exp_ops, disturb ? "R11 R9 op count" : "R9 op count", ops_seen, exp_ops);
        end else begin
            chk(bank[3] == ex && bank[4] == ey && bank[5] == ez, disturb ? "R11 R7 doubled point" : "R7 doubled point",
                bank[3] * 10000 + bank[4] * 100 + bank[5], ex * 10000 + ey * 100 + ez);
            chk(ops_seen == exp_ops, disturb ? "R11 R8 op count" : "R8 op count", ops_seen, exp_ops);
        end
        chk(mul_clash == 0, "R4 multiply with equal sources", mul_clash, 0);
        if (full) chk(hold_err == 0, "R3 fields held while waiting", hold_err, 0);
        if (full) chk(kind_err == 0, "R6 destination within result/scratch range", kind_err, 0);
    endtask

    initial begin
        lat = 0;
        repeat (3) @(negedge clk);
        chk(!op_valid_o && !busy_o && !done_o, "R1 reset state",
            int'(op_valid_o) + int'(busy_o) + int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!op_valid_o && !busy_o && !done_o, "R1 idle after reset",
            int'(op_valid_o) + int'(busy_o) + int'(done_o), 0);

        // sweep every point coordinate triple mod Q
        for (int x = 0; x < Q; x++) begin
            for (int y = 0; y < Q; y++) begin
                for (int z = 0; z < Q; z++) begin
                    run_point(x, y, z, (x + y + z) % 3, 1'b0, (z % 4) == 1 || z == 0);
                end
            end
        end

        // R11: restart attempt and z flag flip while busy
        run_point(3, 7, 2, 2, 1'b1, 1'b1);
        run_point(9, 4, 0, 1, 1'b1, 1'b1);
        run_point(1, 10, 6, 0, 1'b1, 1'b1);

        @(negedge clk);
        chk(!op_valid_o && !busy_o && !done_o, "R1 idle at end",
            int'(op_valid_o) + int'(busy_o) + int'(done_o), 0);
        finish_run();
    end

endmodule